// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This block is a vector datapath that folds short dot products into an array of 32-bit accumulator lanes. It receives an accumulator vector and two source vectors of the same width. Every 32-bit lane of the result is that lane's accumulator plus the products of the source sub-elements that sit inside the same lane position. A 2-bit opcode picks the element size and the overflow rule. With bytes, each lane sums four products of an unsigned byte and a signed byte. With 16-bit words, each lane sums two products of signed words. The sum either wraps to 32 bits or clamps to the signed 32-bit range.

The vector width is a parameter (128 or 256 bits, so 4 or 8 lanes). The result bus has a fixed width, and any bits above the vector width are driven to zero. A parameter also adds an optional output register. With that register in place the block has a latency of one cycle, and a valid flag travels with the data. A host pipeline places the block in an execute stage. It drives `validIn` with the operands and takes the result when `validOut` is high.

Top module: `dpa_unit`

## Requirements
- R1: In byte mode, lane j of the result uses bytes 4j, 4j+1, 4j+2 and 4j+3 of `srcA` and the same byte positions of `srcB`. Byte k is bits [8k+7:8k].
- R2: In byte mode, each `srcA` byte is read as unsigned (0..255) and each `srcB` byte as signed two's complement (-128..127), so 255 times 0x80 gives -32640.
- R3: In word mode, lane j uses 16-bit elements 2j and 2j+1 (element k is bits [16k+15:16k]) of both sources, and both are read as signed.
- R4: A lane result equals accumulator lane j (bits [32j+31:32j] of `accIn`, read as signed) plus all four byte products, or plus both word products.
- R5: In a saturating operation, the complete sum of the accumulator and all products is formed without loss. A sum above 2147483647 returns 0x7FFFFFFF, and a sum below -2147483648 returns 0x80000000.
- R6: In a wrapping operation, the lane result is the low 32 bits of the exact sum.
- R7: The opcode `opSel` encodes 2'b00 as byte wrapping, 2'b01 as byte saturating, 2'b10 as word wrapping, and 2'b11 as word saturating.
- R8: The number of lanes is VEC_W/32. The bits of `result` from VEC_W up to DST_W-1 are always zero.
- R9: With REG_OUT=1, an operation presented with `validIn` high at a rising edge appears on `result` after that edge, and `validOut` is `validIn` delayed by one cycle.
- R10: With REG_OUT=1, a cycle with `validIn` low leaves `result` unchanged, whatever the operands and opcode are.
- R11: While `rstN` is low, `validOut` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operands and opcode are valid this cycle |
| opSel | input | 2 | Operation: byte/word, wrapping/saturating |
| accIn | input | VEC_W | Packed 32-bit accumulator lanes |
| srcA | input | VEC_W | First source vector (bytes unsigned in byte mode) |
| srcB | input | VEC_W | Second source vector (always signed) |
| validOut | output | 1 | Result is valid |
| result | output | DST_W | Packed 32-bit results, upper bits zero |

## Verification
In a single operation, one lane can clamp while the next lane wraps or passes its exact sum. In word mode, one lane can also carry two products of -32768 by -32768, so the word sum alone overflows the 32-bit range before the accumulator is added. Directed vectors build these cases by giving adjacent lanes accumulators near the positive limit, near the negative limit, and near zero under the same opcode. Every lane of the bus is then compared against a reference that computes the full-precision sum and clamps or truncates it. Random operands over all four opcodes fill the gaps. Each compare also checks that the bits above the vector width stay zero.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int LANE_W = 32;
  localparam int SUM_W  = 36;

  typedef enum logic [1:0] {
    OP_BYTE_WRAP = 2'b00,
    OP_BYTE_SAT  = 2'b01,
    OP_WORD_WRAP = 2'b10,
    OP_WORD_SAT  = 2'b11
  } dpaOp_e;

  typedef struct packed {
    logic wordMode;
    logic satEn;
    logic capture;
  } dpaStrobe_t;
endpackage

// File: rtl/dpa_ctrl.sv
module dpa_ctrl
  import dpa_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [1:0] opSel,
  output dpaStrobe_t strobe,
  output logic       validOut
);
  dpaOp_e op;

  always_comb begin
    op = dpaOp_e'(opSel);
    strobe.capture = validIn;
    unique case (op)
      OP_BYTE_WRAP: begin strobe.wordMode = 1'b0; strobe.satEn = 1'b0; end
      OP_BYTE_SAT:  begin strobe.wordMode = 1'b0; strobe.satEn = 1'b1; end
      OP_WORD_WRAP: begin strobe.wordMode = 1'b1; strobe.satEn = 1'b0; end
      default:      begin strobe.wordMode = 1'b1; strobe.satEn = 1'b1; end
    endcase
  end

  generate
    if (REG_OUT != 0) begin : g_reg
      logic validQ;
      logic pastOk;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ <= 1'b0;
          pastOk <= 1'b0;
        end else begin
          validQ <= validIn;
          pastOk <= 1'b1;
        end
      end
      assign validOut = validQ;

      // R9: valid flag is the input flag delayed by one cycle
      a_r9_latency: assert property (@(posedge clk) disable iff (!rstN)
        pastOk |-> (validOut == $past(validIn)));
    end else begin : g_comb
      assign validOut = validIn;
    end
  endgenerate
endmodule

// File: rtl/dpa_lane.sv
module dpa_lane
  import dpa_pkg::*;
(
  input  logic              wordMode,
  input  logic              satEn,
  input  logic [LANE_W-1:0] accIn,
  input  logic [LANE_W-1:0] aIn,
  input  logic [LANE_W-1:0] bIn,
  output logic [LANE_W-1:0] laneOut
);
  localparam int NBYTE = LANE_W / 8;
  localparam int NWORD = LANE_W / 16;
  localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(64'sd2147483647);
  localparam logic signed [SUM_W-1:0] SUM_MIN = -SUM_W'(64'sd2147483648);

  logic signed [SUM_W-1:0] byteSum, wordSum, fullSum;

  always_comb begin
    byteSum = SUM_W'($signed(accIn));
    for (int k = 0; k < NBYTE; k++) begin
      logic signed [17:0] aExt, bExt, prod;
      aExt = 18'(aIn[8*k +: 8]);
      bExt = 18'($signed(bIn[8*k +: 8]));
      prod = aExt * bExt;
      byteSum = byteSum + SUM_W'(prod);
    end
  end

  always_comb begin
    wordSum = SUM_W'($signed(accIn));
    for (int k = 0; k < NWORD; k++) begin
      logic signed [31:0] aExt, bExt, prod;
      aExt = 32'($signed(aIn[16*k +: 16]));
      bExt = 32'($signed(bIn[16*k +: 16]));
      prod = aExt * bExt;
      wordSum = wordSum + SUM_W'(prod);
    end
  end

  always_comb begin
    fullSum = wordMode ? wordSum : byteSum;
    if (satEn && (fullSum > SUM_MAX))      laneOut = 32'h7FFF_FFFF;
    else if (satEn && (fullSum < SUM_MIN)) laneOut = 32'h8000_0000;
    else                                   laneOut = fullSum[LANE_W-1:0];
  end

  always_comb begin
    // R6: wrapping keeps the low bits of the exact sum
    if (!satEn) a_r6_wrap_low: assert (laneOut == fullSum[LANE_W-1:0]);
    // R5: an unclamped saturating result is the exact sum
    if (satEn && laneOut != 32'h7FFF_FFFF && laneOut != 32'h8000_0000)
      a_r5_sat_exact: assert (SUM_W'($signed(laneOut)) == fullSum);
  end
endmodule

// File: rtl/dpa_datapath.sv
module dpa_datapath
  import dpa_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int DST_W   = 256,
  parameter int REG_OUT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpaStrobe_t       strobe,
  input  logic [VEC_W-1:0] accIn,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [DST_W-1:0] result
);
  localparam int NLANE = VEC_W / LANE_W;

  logic [DST_W-1:0] laneVec;

  generate
    for (genvar j = 0; j < NLANE; j++) begin : g_lane
      dpa_lane i_lane (
        .wordMode (strobe.wordMode),
        .satEn    (strobe.satEn),
        .accIn    (accIn[LANE_W*j +: LANE_W]),
        .aIn      (srcA[LANE_W*j +: LANE_W]),
        .bIn      (srcB[LANE_W*j +: LANE_W]),
        .laneOut  (laneVec[LANE_W*j +: LANE_W])
      );
    end
    if (DST_W > VEC_W) begin : g_upper
      assign laneVec[DST_W-1:VEC_W] = '0;
    end

    if (REG_OUT != 0) begin : g_reg
      logic [DST_W-1:0] resQ;
      always_ff @(posedge clk) begin
        if (!rstN)               resQ <= '0;
        else if (strobe.capture) resQ <= laneVec;
      end
      assign result = resQ;

      // R10: no capture strobe leaves the result register untouched
      a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.capture |=> $stable(result));
    end else begin : g_comb
      assign result = laneVec;
    end
  endgenerate
endmodule

// File: rtl/dpa_unit.sv
module dpa_unit
  import dpa_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int DST_W   = 256,
  parameter int REG_OUT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [1:0]       opSel,
  input  logic [VEC_W-1:0] accIn,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic             validOut,
  output logic [DST_W-1:0] result
);
  dpaStrobe_t strobe;

  dpa_ctrl #(.REG_OUT(REG_OUT)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .opSel    (opSel),
    .strobe   (strobe),
    .validOut (validOut)
  );

  dpa_datapath #(.VEC_W(VEC_W), .DST_W(DST_W), .REG_OUT(REG_OUT)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .accIn  (accIn),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result)
  );
endmodule

// File: tb/test_dpa_unit.sv
module test_dpa_unit;
  localparam int VEC_W = 128;
  localparam int DST_W = 256;
  localparam int NLANE = VEC_W / 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             validIn = 1'b0;
  logic [1:0]       opSel = 2'b00;
  logic [VEC_W-1:0] accIn = '0, srcA = '0, srcB = '0;
  logic             validOut;
  logic [DST_W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dpa_unit #(.VEC_W(VEC_W), .DST_W(DST_W), .REG_OUT(1)) i_dpa_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel),
    .accIn(accIn), .srcA(srcA), .srcB(srcB),
    .validOut(validOut), .result(result)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] refLane(input logic [1:0] op,
      input logic [31:0] acc, input logic [31:0] a, input logic [31:0] b);
    longint s = longint'($signed(acc));
    if (!op[1]) begin
      for (int k = 0; k < 4; k++)
        s += longint'(a[8*k +: 8]) * longint'($signed(b[8*k +: 8]));
    end else begin
      for (int k = 0; k < 2; k++)
        s += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
    end
    if (op[0] && s > 64'sd2147483647)  s = 64'sd2147483647;
    if (op[0] && s < -64'sd2147483648) s = -64'sd2147483648;
    return s[31:0];
  endfunction

  function automatic logic [DST_W-1:0] refVec(input logic [1:0] op,
      input logic [VEC_W-1:0] acc, input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    logic [DST_W-1:0] v = '0;
    for (int j = 0; j < NLANE; j++)
      v[32*j +: 32] = refLane(op, acc[32*j +: 32], a[32*j +: 32], b[32*j +: 32]);
    return v;
  endfunction

  task automatic chk(input string req, input logic [DST_W-1:0] act, input logic [DST_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, check at next negedge
  task automatic runOp(input string req, input logic [1:0] op,
      input logic [VEC_W-1:0] acc, input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    @(negedge clk);
    opSel = op; accIn = acc; srcA = a; srcB = b; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    chk({req, " R9 validOut"}, DST_W'(validOut), DST_W'(1));
    chk({req, " R8"}, result, refVec(op, acc, a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DST_W-1:0] held;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    // R11: reset state
    validIn = 1'b1; srcA = '1; srcB = '1; accIn = '1;
    @(negedge clk);
    chk("R11 reset result", result, '0);
    chk("R11 reset validOut", DST_W'(validOut), '0);
    validIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 idle validOut", DST_W'(validOut), '0);

    // R1: distinct bytes show lane mapping
    runOp("R1 byte map", 2'b00, '0,
          128'h04030201_08070605_0C0B0A09_100F0E0D,
          128'h01010101_01FF0102_02020202_FF010101);
    // R2: 255 x -128 in every byte, accumulator min, saturating and wrapping
    runOp("R2 R5 byte sat low", 2'b01,
          {32'h8000_0000, 32'h8000_7F80, 32'h0000_0000, 32'h7FFF_FFFF},
          {4{32'hFFFF_FFFF}}, {4{32'h8080_8080}});
    runOp("R2 R6 byte wrap low", 2'b00,
          {32'h8000_0000, 32'h8000_7F80, 32'h0000_0000, 32'h7FFF_FFFF},
          {4{32'hFFFF_FFFF}}, {4{32'h8080_8080}});
    // R3: -32768 x -32768 in both word positions, lanes at limits
    runOp("R3 R5 word sat", 2'b11,
          {32'h0000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0001},
          {4{32'h8000_8000}}, {4{32'h8000_8000}});
    runOp("R3 R6 word wrap", 2'b10,
          {32'h0000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0001},
          {4{32'h8000_8000}}, {4{32'h8000_8000}});
    // R5: near positive and negative limits with small products
    runOp("R5 word sat near max", 2'b11,
          {32'h7FFF_FFFE, 32'h7FFF_FFFD, 32'h8000_0001, 32'h8000_0002},
          {32'h0001_0001, 32'h0001_0001, 32'h0001_0001, 32'hFFFF_0001},
          {32'h0001_0001, 32'h0001_0001, 32'hFFFF_FFFF, 32'h0001_0001});
    runOp("R5 byte sat near max", 2'b01,
          {32'h7FFF_FF00, 32'h7FFF_0000, 32'h8000_0100, 32'h8000_0000},
          {4{32'hFFFF_FFFF}}, {32'h7F7F_7F7F, 32'h7F7F_7F7F, 32'h8080_8080, 32'h0000_0001});

    // R4 R7: random over all opcodes
    for (int n = 0; n < 300; n++) begin
      logic [VEC_W-1:0] ra, rb, rc;
      for (int w = 0; w < VEC_W / 32; w++) begin
        ra[32*w +: 32] = $urandom; rb[32*w +: 32] = $urandom; rc[32*w +: 32] = $urandom;
      end
      if (n % 5 == 0) rc[31:0] = 32'h7FFF_FF00 + ($urandom % 256);
      runOp("R4 R7 random", 2'($urandom % 4), rc, ra, rb);
    end

    // R10: hold while validIn low
    held = result;
    @(negedge clk);
    opSel = 2'b11; accIn = '1; srcA = '1; srcB = '1;
    @(negedge clk);
    chk("R10 hold result", result, held);
    chk("R10 hold validOut", DST_W'(validOut), '0);
    // R9: back-to-back operations, one per cycle
    @(negedge clk);
    opSel = 2'b10; accIn = {4{32'd5}}; srcA = {4{32'h0002_0003}}; srcB = {4{32'h0004_0005}};
    validIn = 1'b1;
    @(negedge clk);
    chk("R9 first of pair", result, refVec(2'b10, {4{32'd5}}, {4{32'h0002_0003}}, {4{32'h0004_0005}}));
    opSel = 2'b00; accIn = {4{32'd1}}; srcA = {4{32'h0101_0101}}; srcB = {4{32'h0101_0101}};
    @(negedge clk);
    validIn = 1'b0;
    chk("R9 second of pair", result, refVec(2'b00, {4{32'd1}}, {4{32'h0101_0101}}, {4{32'h0101_0101}}));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule